// File: doc/BRIEF.md
# Random Allocation Tag Inserter

This block picks a pseudo-random 4-bit allocation tag and writes it into a 64-bit pointer. A 16-bit seed and the most recently chosen tag live together in one state register. When an operation is requested, the seed is stepped four times through a shift-register generator. The four feedback bits form a step count. The previous tag is then walked around the ring of sixteen tag values by that many places, and any value forbidden by the combined exclusion mask is skipped.

The result goes out one cycle after the request, together with a one-cycle valid pulse. When tag access is disabled, the pointer goes out with its tag field cleared and the state is not changed. Software can load the state register directly to seed the sequence.

Top module: `rand_tag_inserter`

## Requirements
- R1: After reset, state_o, ptr_o and valid_o are all zero.
- R2: Each operation with tag access enabled advances the seed (state_o[23:8]) by four steps. In each step the feedback is the XOR of seed bits 5, 3, 2 and 0, the seed shifts right by one, and the feedback enters at bit 15.
- R3: The feedback of step i (i = 0..3) is bit i of the step count, so the first step gives the least significant bit. An all-zero seed therefore always gives a step count of 0 and stays zero.
- R4: The exclusion mask is excl_op_i OR excl_ctl_i. Bit n set forbids tag n, and a forbidden tag is never chosen while at least one tag is allowed.
- R5: If all sixteen tags are forbidden, the chosen tag is 0.
- R6: With a step count of 0, the chosen tag is the previous tag (state_o[3:0]) if that tag is allowed. Otherwise it is the first allowed value found by counting upward modulo 16.
- R7: With a nonzero step count k, the tag moves k times. Each move goes to the next allowed value strictly after the current one, modulo 16.
- R8: With tag access enabled, ptr_o equals ptr_i with bits 59:56 replaced by the chosen tag. The chosen tag is also stored in state_o[3:0], and state_o[7:4] reads zero.
- R9: With tag access disabled, ptr_o equals ptr_i with bits 59:56 cleared, and state_o does not change.
- R10: valid_o is high in exactly the cycle after a cycle with start_i high. ptr_o holds its value until the next operation.
- R11: st_wr_i loads the seed from st_wdata_i[23:8] and the tag from st_wdata_i[3:0], visible on the next cycle. It overrides the state update of an operation in the same cycle, but that operation still uses the old state for its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one tag operation |
| tag_en_i | input | 1 | Tag access enable for the operation |
| ptr_i | input | 64 | Source pointer |
| excl_op_i | input | 16 | Exclusion mask from the operand |
| excl_ctl_i | input | 16 | Exclusion mask from the control register |
| st_wr_i | input | 1 | Software write of the state register |
| st_wdata_i | input | 24 | State write data: seed in 23:8, tag in 3:0 |
| ptr_o | output | 64 | Tagged pointer |
| valid_o | output | 1 | Result valid pulse |
| state_o | output | 24 | State register: seed in 23:8, tag in 3:0 |

## Verification
The bench targets the all-zero seed. A wrong tap or shift direction shows up there as a nonzero step count, or as a seed that leaves zero. It also drives a previous tag that is itself excluded under a zero step count; a design that skips the upward search returns a forbidden tag. It uses a fully excluded mask, where a naive walk would spin or return the start value instead of zero. Finally, it issues a state write in the same cycle as an operation and a disabled operation, where a wrong priority or a missing enable guard corrupts the stored seed.

// File: rtl/rtag_pkg.sv
`timescale 1ns/1ps
// Shared widths and the ring search helper for the tag inserter.
// Assumes a ring of 2**TAG_W tags with one mask bit per tag.
package rtag_pkg;
    localparam int TAG_W    = 4;
    localparam int NTAGS    = 1 << TAG_W;
    localparam int SEED_W   = 16;
    localparam int SEED_LSB = 8;
    localparam int ST_W     = SEED_LSB + SEED_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [NTAGS-1:0]  mask_t;
    typedef logic [SEED_W-1:0] seed_t;

    // First allowed tag strictly after t, scanning a full lap (t itself last).
    function automatic tag_t next_allowed(input tag_t t, input mask_t m);
        tag_t r;
        tag_t cand;
        r = t;
        for (int i = NTAGS; i >= 1; i--) begin
            cand = tag_t'(t + tag_t'(i));
            if (!m[cand]) r = cand;
        end
        return r;
    endfunction
endpackage

// File: rtl/rtag_lfsr.sv
`timescale 1ns/1ps
// Advances a Fibonacci shift-register seed by STEPS steps in one cycle.
// The feedback of step i is returned as bit i of step_cnt_o.
// Assumes TAP_MASK selects the XOR taps and feedback enters at the top bit.
module rtag_lfsr
    import rtag_pkg::*;
#(
    parameter int    STEPS    = TAG_W,
    parameter seed_t TAP_MASK = 16'h002D
) (
    input  seed_t            seed_i,
    output seed_t            seed_o,
    output logic [STEPS-1:0] step_cnt_o
);
    seed_t chain [STEPS+1];

    assign chain[0] = seed_i;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic fb;
        // Feedback of this step and the shifted seed it produces.
        assign fb            = ^(chain[i] & TAP_MASK);
        assign chain[i+1]    = {fb, chain[i][SEED_W-1:1]};
        assign step_cnt_o[i] = fb;
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/rtag_ring_walk.sv
`timescale 1ns/1ps
// Moves a tag around the ring by a step count while skipping excluded tags.
// A step count of zero only searches upward for the first allowed tag.
// A fully excluded ring yields tag 0. The search is purely combinational.
module rtag_ring_walk
    import rtag_pkg::*;
(
    input  tag_t  start_i,
    input  tag_t  step_cnt_i,
    input  mask_t mask_i,
    output tag_t  tag_o
);
    tag_t hop [NTAGS];

    assign hop[0] = start_i;

    for (genvar j = 1; j < NTAGS; j++) begin : g_hop
        // One move to the next allowed tag.
        assign hop[j] = next_allowed(hop[j-1], mask_i);
    end

    // Pick the hop that matches the step count, or handle the special cases.
    always_comb begin
        if (&mask_i)
            tag_o = '0;
        else if (step_cnt_i == '0)
            tag_o = next_allowed(tag_t'(start_i - tag_t'(1)), mask_i);
        else
            tag_o = hop[step_cnt_i];
    end
endmodule

// File: rtl/rand_tag_inserter.sv
`timescale 1ns/1ps
// Random allocation tag inserter: on start_i, steps the seed, walks the tag
// ring and writes the chosen tag into bits TAG_LSB+3:TAG_LSB of the pointer.
// The result is registered, so valid_o pulses one cycle after start_i.
// Assumes software writes of the state register override the operation's update.
module rand_tag_inserter
    import rtag_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int TAG_LSB = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tag_en_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [15:0]      excl_op_i,
    input  logic [15:0]      excl_ctl_i,
    input  logic             st_wr_i,
    input  logic [ST_W-1:0]  st_wdata_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             valid_o,
    output logic [ST_W-1:0]  state_o
);
    seed_t            seed_q, seed_nx;
    tag_t             tag_q, tag_nx, step_cnt;
    mask_t            eff_mask;
    logic [PTR_W-1:0] ptr_q, ptr_ins;
    logic             valid_q;

    // Combined exclusion mask.
    assign eff_mask = excl_op_i | excl_ctl_i;

    rtag_lfsr #(.STEPS(TAG_W)) u_lfsr (
        .seed_i    (seed_q),
        .seed_o    (seed_nx),
        .step_cnt_o(step_cnt)
    );

    rtag_ring_walk u_walk (
        .start_i   (tag_q),
        .step_cnt_i(step_cnt),
        .mask_i    (eff_mask),
        .tag_o     (tag_nx)
    );

    // Insert the chosen tag, or zero when tag access is off.
    always_comb begin
        ptr_ins                     = ptr_i;
        ptr_ins[TAG_LSB +: TAG_W]   = tag_en_i ? tag_nx : tag_t'(0);
    end

    // Output register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start_i;
            if (start_i) ptr_q <= ptr_ins;
        end
    end

    // State register: operation update, then software write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= '0;
            tag_q  <= '0;
        end else if (st_wr_i) begin
            seed_q <= st_wdata_i[SEED_LSB +: SEED_W];
            tag_q  <= st_wdata_i[TAG_W-1:0];
        end else if (start_i && tag_en_i) begin
            seed_q <= seed_nx;
            tag_q  <= tag_nx;
        end
    end

    assign ptr_o   = ptr_q;
    assign valid_o = valid_q;
    assign state_o = {seed_q, {(SEED_LSB-TAG_W){1'b0}}, tag_q};

    // R10
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i));

    // R9
    disabled_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !tag_en_i && !st_wr_i) |=> $stable(state_o));

    // R9
    disabled_clears_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !tag_en_i) |=> (ptr_o[TAG_LSB +: TAG_W] == '0));

    // R8
    tag_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && tag_en_i && !st_wr_i) |=> (ptr_o[TAG_LSB +: TAG_W] == state_o[TAG_W-1:0]));

    // R4
    allowed_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && tag_en_i && !(&eff_mask)) |-> !eff_mask[tag_nx]);

    // R11
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_i |=> (state_o[ST_W-1:SEED_LSB] == $past(st_wdata_i[ST_W-1:SEED_LSB])
                     && state_o[TAG_W-1:0] == $past(st_wdata_i[TAG_W-1:0])));
endmodule

// File: tb/rand_tag_inserter_bench.sv
`timescale 1ns/1ps
module rand_tag_inserter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, tag_en_i = 1'b0, st_wr_i = 1'b0;
    logic [63:0] ptr_i = '0;
    logic [15:0] excl_op_i = '0, excl_ctl_i = '0;
    logic [23:0] st_wdata_i = '0;
    logic [63:0] ptr_o;
    logic        valid_o;
    logic [23:0] state_o;

    int errors = 0, checks = 0;
    bit done = 0;

    // Reference state and expected outputs.
    int          m_seed = 0, m_tag = 0;
    logic [63:0] e_ptr = '0;
    logic        e_valid = 1'b0;

    always #4 clk = ~clk;

    rand_tag_inserter u_rand_tag_inserter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tag_en_i(tag_en_i),
        .ptr_i(ptr_i), .excl_op_i(excl_op_i), .excl_ctl_i(excl_ctl_i),
        .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
        .ptr_o(ptr_o), .valid_o(valid_o), .state_o(state_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural model of one operation: returns new tag, updates seed arg.
    function automatic int model_op(inout int seed, input int tag, input int mask);
        int steps = 0;
        int t = tag;
        for (int i = 0; i < 4; i++) begin
            int fb = ((seed >> 5) ^ (seed >> 3) ^ (seed >> 2) ^ seed) & 1;
            seed  = (fb << 15) | (seed >> 1);
            steps = steps | (fb << i);
        end
        if (mask == 16'hFFFF) return 0;
        if (steps == 0) begin
            while ((mask >> t) & 1) t = (t + 1) % 16;
        end else begin
            repeat (steps) begin
                t = (t + 1) % 16;
                while ((mask >> t) & 1) t = (t + 1) % 16;
            end
        end
        return t;
    endfunction

    // Drive one cycle at the falling edge, advance the model, check next fall.
    task automatic cyc(bit st, bit en, logic [63:0] p, logic [15:0] mo,
                       logic [15:0] mc, bit wr, logic [23:0] wd, string req);
        int s, t;
        start_i = st; tag_en_i = en; ptr_i = p; excl_op_i = mo;
        excl_ctl_i = mc; st_wr_i = wr; st_wdata_i = wd;
        e_valid = st;
        s = m_seed;
        if (st) begin
            t = en ? model_op(s, m_tag, int'(mo | mc)) : 0;
            e_ptr = p;
            e_ptr[59:56] = t[3:0];
            if (en) begin m_seed = s; m_tag = t; end
        end
        if (wr) begin m_seed = int'(wd[23:8]); m_tag = int'(wd[3:0]); end
        @(negedge clk);
        check("R10", {63'd0, valid_o}, {63'd0, e_valid});
        check(req, ptr_o, e_ptr);
        check(req, {40'd0, state_o},
              {40'd0, m_seed[15:0], 4'd0, m_tag[3:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", ptr_o, 64'd0);
        check("R1", {63'd0, valid_o}, 64'd0);
        check("R1", {40'd0, state_o}, 64'd0);
        // R3 zero seed gives step 0; R6 excluded start searches upward to 3
        cyc(1, 1, 64'h0123_4567_89AB_CDEF, 16'h0003, 16'h0004, 0, 0, "R6");
        cyc(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 16'h0000, 0, 0, "R3");
        // R11 software seeding, then a run with no exclusions (R2, R7)
        cyc(0, 0, 0, 0, 0, 1, 24'hACE1_05, "R11");
        for (int i = 0; i < 6; i++)
            cyc(1, 1, 64'h0FFF_0000_1234_5678 + 64'(i), 0, 0, 0, 0, "R7");
        // R4 operand and control masks combine
        cyc(1, 1, 64'hF0F0_F0F0_F0F0_F0F0, 16'h5555, 16'h0A0A, 0, 0, "R4");
        cyc(1, 1, 64'h1111_2222_3333_4444, 16'h00F0, 16'hF000, 0, 0, "R4");
        // R5 all tags excluded
        cyc(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFF00, 16'h00FF, 0, 0, "R5");
        // R9 disabled tag access
        cyc(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 16'h0000, 0, 0, "R9");
        // R10 idle cycles hold pointer
        cyc(0, 1, 64'h0, 0, 0, 0, 0, "R10");
        cyc(0, 1, 64'h0, 0, 0, 0, 0, "R10");
        // R11 write with same-cycle operation
        cyc(1, 1, 64'h0A0A_0A0A_0A0A_0A0A, 16'h0000, 0, 1, 24'h1234_0C, "R11");
        cyc(1, 1, 64'h7777_7777_7777_7777, 16'h0000, 0, 0, 0, "R8");
        // R7/R8 varied patterns
        for (int i = 0; i < 60; i++)
            cyc(1'($urandom), 1'($urandom_range(0, 5) != 0),
                {$urandom, $urandom}, 16'($urandom) & 16'($urandom),
                16'($urandom) & 16'($urandom) & 16'($urandom),
                1'($urandom_range(0, 9) == 0), 24'($urandom), "R7");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule